// File: doc/BRIEF.md
# Serial Command Packet Receiver

This block sits behind a byte-wide UART receiver on a 19200 baud, 8N1 control link with no flow control. It watches the incoming byte stream for a two-byte little-endian sync word, collects a seven-byte header, and then collects a payload whose length depends on the packet type. The header carries the type, a 16-bit payload size and a 16-bit checksum. The checksum is a CRC over every byte of the packet, with the two checksum bytes fed in as zero.

When a packet passes every check, the block raises a one-cycle result. An event packet presents an event number and a 32-bit argument. An operation packet presents an operation code, an operation number, an availability word and five 32-bit words. A link-setup packet produces only an acknowledge. Each accepted packet also requests a single acknowledge byte for the transmit side.

A rejected packet produces no acknowledge and adds one to an error counter. A packet is rejected for a bad type, a wrong size or a wrong checksum. A packet that stalls in the middle is dropped after a programmable silence, and the block goes back to looking for sync.

Top module: `pkt_cmd_rx`

## Requirements
- R1: While searching, every byte other than 0xBE is discarded. Sync is found only when 0xBE is immediately followed by 0xEF. If a 0xBE arrives where 0xEF is expected, that 0xBE becomes the new first sync byte.
- R2: After sync, the header bytes are, in order: type, size low byte, size high byte, check low byte, check high byte. The payload size is {high,low}, least-significant byte first, so a non-zero high byte makes any defined type's size wrong.
- R3: The only accepted type/size pairs are type 1 with size 5 (link setup), type 2 with size 6 (event) and type 3 with size 25 (operation). Any other type, or any other size, rejects the packet as soon as the size high byte arrives.
- R4: The check value is the CRC with polynomial CRC_POLY (default 0x1021), initial value CRC_INIT (default 0), processed MSB-first and non-reflected. It is computed over all packet bytes, sync included, with the two check bytes replaced by zero. If it differs from the received {high,low} check value, the packet is rejected.
- R5: In an accepted event packet, payload bytes 0-1 form evt_id and bytes 2-5 form evt_param, both least-significant byte first.
- R6: In an accepted operation packet, the payload fields are packed back to back, each least-significant byte first: byte 0 is op_code, bytes 1-2 op_id, bytes 3-4 op_avail, then target, value, minimum, maximum and increment at 4 bytes each, starting at byte 5.
- R7: In the cycle after the last byte of an accepted packet is sampled, ack_valid is high for exactly one cycle. ack_byte is 0x06 for event and operation packets and 0x1E for link-setup packets. evt_valid or op_valid rises together with ack_valid, and never without it.
- R8: Each rejected packet, for a bad type, size or check, raises err_count by exactly one (saturating) and produces no acknowledge. Accepted packets leave err_count unchanged.
- R9: If no byte arrives for CLKS_PER_BYTE*TIMEOUT_BYTES cycles while a packet is only partly received, the packet is dropped without an error count and the block returns to searching.
- R10: After reset, ack_valid, evt_valid and op_valid are low and err_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Request to send ack_byte to the host |
| ack_byte | output | 8 | Acknowledge code (0x06 or 0x1E) |
| evt_valid | output | 1 | Event fields are valid this cycle |
| evt_id | output | 16 | Event number |
| evt_param | output | 32 | Event argument |
| op_valid | output | 1 | Operation fields are valid this cycle |
| op_code | output | 8 | Operation code (1 set, 2 get, 3 increment, 4 decrement, 5 execute) |
| op_id | output | 16 | Operation number |
| op_avail | output | 16 | Availability word |
| op_target | output | 32 | Operation target |
| op_value | output | 32 | Operation value |
| op_min | output | 32 | Minimum bound |
| op_max | output | 32 | Maximum bound |
| op_inc | output | 32 | Step size |
| err_count | output | ERR_W | Count of rejected packets |

## Verification
The hardest situations to reach from the ports are the sync restart and the stalled partial packet. Both depend on exactly what the stream held just before a good packet.

For the restart, the stimulus sends a stray 0xBE followed by a packet that itself begins with 0xBE. The packet is then accepted only if the second 0xBE restarts the search.

For the stall, the stimulus sends a truncated header, stays silent past the timeout, and then sends a complete packet. Without the abort, the new sync bytes would be swallowed as payload and no acknowledge would appear.

Checksum failures are produced by flipping one bit in the check field or in the payload after the correct value has been computed.

// File: rtl/pkt_rx_pkg.sv
`timescale 1ns/1ps
package pkt_rx_pkg;

    localparam logic [7:0] SYNC_LO   = 8'hBE;
    localparam logic [7:0] SYNC_HI   = 8'hEF;
    localparam logic [7:0] ACK_CMD   = 8'h06;
    localparam logic [7:0] ACK_SETUP = 8'h1E;

    localparam int MAX_PAY   = 25;
    localparam int PAY_IW    = $clog2(MAX_PAY);
    localparam int LEN_SETUP = 5;
    localparam int LEN_EVENT = 6;
    localparam int LEN_OPER  = 25;
    localparam int OP_WORDS  = 5;
    localparam int OP_WBASE  = 5;

    typedef enum logic [3:0] {
        ST_HUNT, ST_SYNC_HI, ST_TYPE, ST_LEN_LO, ST_LEN_HI,
        ST_CHK_LO, ST_CHK_HI, ST_BODY
    } rx_state_t;

    typedef enum logic [1:0] {PK_NONE, PK_SETUP, PK_EVENT, PK_OPER} pkt_kind_t;

    typedef struct packed {
        logic [15:0] id;
        logic [31:0] param;
    } event_t;

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] id;
        logic [15:0] avail;
        logic [31:0] target;
        logic [31:0] value;
        logic [31:0] minv;
        logic [31:0] maxv;
        logic [31:0] incr;
    } oper_t;

    function automatic pkt_kind_t kind_of(input logic [7:0] t);
        case (t)
            8'd1:    return PK_SETUP;
            8'd2:    return PK_EVENT;
            8'd3:    return PK_OPER;
            default: return PK_NONE;
        endcase
    endfunction

    function automatic logic [15:0] len_of(input pkt_kind_t k);
        case (k)
            PK_SETUP: return 16'(LEN_SETUP);
            PK_EVENT: return 16'(LEN_EVENT);
            PK_OPER:  return 16'(LEN_OPER);
            default:  return 16'd0;
        endcase
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_crc_acc.sv
`timescale 1ns/1ps
module pkt_crc_acc
    import pkt_rx_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc_nxt
);
    logic [15:0] crc_q;
    logic [15:0] base;

    assign base    = clear ? INIT : crc_q;
    assign crc_nxt = crc_step(base, din, POLY);

    always_ff @(posedge clk) begin
        if (rst)        crc_q <= INIT;
        else if (feed)  crc_q <= crc_nxt;
        else if (clear) crc_q <= INIT;
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!feed && !clear) |=> $stable(crc_q)); // R4

endmodule

// File: rtl/pkt_framer.sv
`timescale 1ns/1ps
module pkt_framer
    import pkt_rx_pkg::*;
#(
    parameter int IDLE_LIMIT = 104168
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_byte,
    output logic                       crc_clear,
    output logic                       crc_feed,
    output logic [7:0]                 crc_din,
    input  logic [15:0]                crc_nxt,
    output logic                       done,
    output logic                       good,
    output pkt_kind_t                  kind,
    output logic                       hdr_err,
    output logic [MAX_PAY-1:0][7:0]    pay_q
);
    localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

    rx_state_t         state;
    logic [IDLE_W-1:0] idle_cnt;
    logic [7:0]        typ;
    logic [7:0]        len_lo;
    logic [15:0]       chk_rx;
    logic [PAY_IW-1:0] pay_idx;
    pkt_kind_t         cur_kind;
    logic              len_ok;
    logic [PAY_IW-1:0] last_idx;
    logic              timeout;

    assign cur_kind = kind_of(typ);
    assign len_ok   = (cur_kind != PK_NONE) && ({rx_byte, len_lo} == len_of(cur_kind));
    assign last_idx = PAY_IW'(len_of(cur_kind) - 16'd1);
    assign timeout  = (state != ST_HUNT) && !rx_valid
                      && (idle_cnt == IDLE_W'(IDLE_LIMIT - 1));

    // Checksum feed: sync restarts it, check bytes enter as zero
    always_comb begin
        crc_clear = 1'b0;
        crc_feed  = 1'b0;
        crc_din   = rx_byte;
        if (rx_valid) begin
            case (state)
                ST_HUNT: begin
                    crc_clear = (rx_byte == SYNC_LO);
                    crc_feed  = (rx_byte == SYNC_LO);
                end
                ST_SYNC_HI: begin
                    crc_clear = (rx_byte == SYNC_LO);
                    crc_feed  = (rx_byte == SYNC_LO) || (rx_byte == SYNC_HI);
                end
                ST_CHK_LO, ST_CHK_HI: begin
                    crc_feed = 1'b1;
                    crc_din  = 8'h00;
                end
                default: crc_feed = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            idle_cnt <= '0;
            typ      <= '0;
            len_lo   <= '0;
            chk_rx   <= '0;
            pay_idx  <= '0;
            pay_q    <= '0;
            done     <= 1'b0;
            good     <= 1'b0;
            kind     <= PK_NONE;
            hdr_err  <= 1'b0;
        end else begin
            done    <= 1'b0;
            hdr_err <= 1'b0;
            if (timeout) begin
                state    <= ST_HUNT;
                idle_cnt <= '0;
            end else if (rx_valid) begin
                idle_cnt <= '0;
                case (state)
                    ST_HUNT: begin
                        if (rx_byte == SYNC_LO) state <= ST_SYNC_HI;
                    end
                    ST_SYNC_HI: begin
                        if (rx_byte == SYNC_HI)      state <= ST_TYPE;
                        else if (rx_byte != SYNC_LO) state <= ST_HUNT;
                    end
                    ST_TYPE: begin
                        typ   <= rx_byte;
                        state <= ST_LEN_LO;
                    end
                    ST_LEN_LO: begin
                        len_lo <= rx_byte;
                        state  <= ST_LEN_HI;
                    end
                    ST_LEN_HI: begin
                        if (len_ok) begin
                            state <= ST_CHK_LO;
                        end else begin
                            hdr_err <= 1'b1;
                            state   <= ST_HUNT;
                        end
                    end
                    ST_CHK_LO: begin
                        chk_rx[7:0] <= rx_byte;
                        state       <= ST_CHK_HI;
                    end
                    ST_CHK_HI: begin
                        chk_rx[15:8] <= rx_byte;
                        pay_idx      <= '0;
                        state        <= ST_BODY;
                    end
                    ST_BODY: begin
                        pay_q[pay_idx] <= rx_byte;
                        pay_idx        <= pay_idx + 1'b1;
                        if (pay_idx == last_idx) begin
                            done  <= 1'b1;
                            good  <= (crc_nxt == chk_rx);
                            kind  <= cur_kind;
                            state <= ST_HUNT;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end else if (state != ST_HUNT) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    AST_HUNT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && rx_valid && rx_byte != SYNC_LO) |=> state == ST_HUNT); // R1
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYNC_HI && rx_valid && rx_byte == SYNC_LO) |=> state == ST_SYNC_HI); // R1
    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        idle_cnt < IDLE_W'(IDLE_LIMIT)); // R9
    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rx_valid)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_HDR_ERR_HUNT: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> state == ST_HUNT); // R3

endmodule

// File: rtl/pkt_decode.sv
`timescale 1ns/1ps
module pkt_decode
    import pkt_rx_pkg::*;
(
    input  logic [MAX_PAY-1:0][7:0] pay,
    output event_t                  evt,
    output oper_t                   op
);
    logic [OP_WORDS-1:0][31:0] words;

    for (genvar g = 0; g < OP_WORDS; g++) begin : g_word
        assign words[g] = {pay[OP_WBASE + 4*g + 3], pay[OP_WBASE + 4*g + 2],
                           pay[OP_WBASE + 4*g + 1], pay[OP_WBASE + 4*g]};
    end

    always_comb begin
        evt.id    = {pay[1], pay[0]};
        evt.param = {pay[5], pay[4], pay[3], pay[2]};
        op.code   = pay[0];
        op.id     = {pay[2], pay[1]};
        op.avail  = {pay[4], pay[3]};
        op.target = words[0];
        op.value  = words[1];
        op.minv   = words[2];
        op.maxv   = words[3];
        op.incr   = words[4];
    end

endmodule

// File: rtl/pkt_err_ctr.sv
`timescale 1ns/1ps
module pkt_err_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (inc && count != '1)  count <= count + 1'b1;
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count)); // R8
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && count != '1) |=> count == $past(count) + 1'b1); // R8

endmodule

// File: rtl/pkt_cmd_rx.sv
`timescale 1ns/1ps
module pkt_cmd_rx
    import pkt_rx_pkg::*;
#(
    parameter logic [15:0] CRC_POLY      = 16'h1021,
    parameter logic [15:0] CRC_INIT      = 16'h0000,
    parameter int          CLKS_PER_BYTE = 26042,
    parameter int          TIMEOUT_BYTES = 4,
    parameter int          ERR_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             ack_valid,
    output logic [7:0]       ack_byte,
    output logic             evt_valid,
    output logic [15:0]      evt_id,
    output logic [31:0]      evt_param,
    output logic             op_valid,
    output logic [7:0]       op_code,
    output logic [15:0]      op_id,
    output logic [15:0]      op_avail,
    output logic [31:0]      op_target,
    output logic [31:0]      op_value,
    output logic [31:0]      op_min,
    output logic [31:0]      op_max,
    output logic [31:0]      op_inc,
    output logic [ERR_W-1:0] err_count
);
    localparam int IDLE_LIMIT = CLKS_PER_BYTE * TIMEOUT_BYTES;

    logic                    crc_clear;
    logic                    crc_feed;
    logic [7:0]              crc_din;
    logic [15:0]             crc_nxt;
    logic                    done;
    logic                    good;
    pkt_kind_t               kind;
    logic                    hdr_err;
    logic [MAX_PAY-1:0][7:0] pay_q;
    event_t                  evt;
    oper_t                   op;
    logic                    err_inc;

    pkt_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst(rst), .clear(crc_clear), .feed(crc_feed),
        .din(crc_din), .crc_nxt(crc_nxt)
    );

    pkt_framer #(.IDLE_LIMIT(IDLE_LIMIT)) u_framer (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .crc_clear(crc_clear), .crc_feed(crc_feed), .crc_din(crc_din),
        .crc_nxt(crc_nxt), .done(done), .good(good), .kind(kind),
        .hdr_err(hdr_err), .pay_q(pay_q)
    );

    pkt_decode u_decode (.pay(pay_q), .evt(evt), .op(op));

    assign err_inc = hdr_err || (done && !good);

    pkt_err_ctr #(.W(ERR_W)) u_err (
        .clk(clk), .rst(rst), .inc(err_inc), .count(err_count)
    );

    assign ack_valid = done && good;
    assign ack_byte  = (kind == PK_SETUP) ? ACK_SETUP : ACK_CMD;
    assign evt_valid = ack_valid && (kind == PK_EVENT);
    assign op_valid  = ack_valid && (kind == PK_OPER);

    assign evt_id    = evt.id;
    assign evt_param = evt.param;
    assign op_code   = op.code;
    assign op_id     = op.id;
    assign op_avail  = op.avail;
    assign op_target = op.target;
    assign op_value  = op.value;
    assign op_min    = op.minv;
    assign op_max    = op.maxv;
    assign op_inc    = op.incr;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(evt_valid && op_valid)); // R7
    AST_CMD_ACK_CODE: assert property (@(posedge clk) disable iff (rst)
        (evt_valid || op_valid) |-> (ack_valid && ack_byte == ACK_CMD)); // R7
    AST_NO_ACK_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
        err_inc |-> !ack_valid); // R8

endmodule

// File: tb/sim_pkt_cmd_rx.sv
`timescale 1ns/1ps
module sim_pkt_cmd_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        ack_valid, evt_valid, op_valid;
    logic [7:0]  ack_byte, op_code;
    logic [15:0] evt_id, op_id, op_avail;
    logic [31:0] evt_param, op_target, op_value, op_min, op_max, op_inc;
    logic [7:0]  err_count;

    always #10 clk = ~clk;

    pkt_cmd_rx #(.CLKS_PER_BYTE(4), .TIMEOUT_BYTES(5), .ERR_W(8)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_valid(ack_valid), .ack_byte(ack_byte),
        .evt_valid(evt_valid), .evt_id(evt_id), .evt_param(evt_param),
        .op_valid(op_valid), .op_code(op_code), .op_id(op_id), .op_avail(op_avail),
        .op_target(op_target), .op_value(op_value), .op_min(op_min),
        .op_max(op_max), .op_inc(op_inc), .err_count(err_count)
    );

    typedef struct packed {
        logic [1:0]   kind;   // 1 setup, 2 event, 3 operation
        logic [7:0]   ack;
        logic [15:0]  eid;
        logic [31:0]  eprm;
        logic [7:0]   oc;
        logic [15:0]  oid;
        logic [15:0]  oav;
        logic [159:0] ow;     // [31:0] target .. [159:128] increment
    } exp_t;

    exp_t       exp_q[$];
    exp_t       me;
    logic [7:0] pk[0:63];
    int         pk_n = 0;
    int         exp_err = 0;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb;
            fb = r[15] ^ b[k];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_hdr(input logic [7:0] typ, input logic [15:0] size);
        pk[0] = 8'hBE; pk[1] = 8'hEF; pk[2] = typ;
        pk[3] = size[7:0]; pk[4] = size[15:8];
        pk[5] = 8'h00; pk[6] = 8'h00;
        pk_n = 7;
    endtask

    task automatic seal();
        logic [15:0] c;
        c = 16'h0000;
        pk[5] = 8'h00; pk[6] = 8'h00;
        for (int i = 0; i < pk_n; i++) c = ref_crc(c, pk[i]);
        pk[5] = c[7:0];
        pk[6] = c[15:8];
    endtask

    task automatic tx_frame();
        for (int i = 0; i < pk_n; i++) send_byte(pk[i]);
    endtask

    task automatic build_event(input logic [15:0] id, input logic [31:0] prm);
        put_hdr(8'd2, 16'd6);
        pk[7] = id[7:0]; pk[8] = id[15:8];
        for (int k = 0; k < 4; k++) pk[9+k] = prm[8*k +: 8];
        pk_n = 13;
        seal();
    endtask

    task automatic send_event(input logic [15:0] id, input logic [31:0] prm);
        exp_t e;
        build_event(id, prm);
        e = '0; e.kind = 2'd2; e.ack = 8'h06; e.eid = id; e.eprm = prm;
        exp_q.push_back(e);
        tx_frame();
        gap(40);
    endtask

    task automatic send_oper(input logic [7:0] oc, input logic [15:0] oid,
                             input logic [15:0] oav, input logic [159:0] ow);
        exp_t e;
        put_hdr(8'd3, 16'd25);
        pk[7] = oc;
        pk[8] = oid[7:0]; pk[9] = oid[15:8];
        pk[10] = oav[7:0]; pk[11] = oav[15:8];
        for (int w = 0; w < 5; w++)
            for (int k = 0; k < 4; k++) pk[12 + 4*w + k] = ow[32*w + 8*k +: 8];
        pk_n = 32;
        seal();
        e = '0; e.kind = 2'd3; e.ack = 8'h06; e.oc = oc; e.oid = oid; e.oav = oav; e.ow = ow;
        exp_q.push_back(e);
        tx_frame();
        gap(40);
    endtask

    task automatic send_setup();
        exp_t e;
        put_hdr(8'd1, 16'd5);
        pk[7] = 8'h01; pk[8] = 8'h02; pk[9] = 8'h00; pk[10] = 8'h00; pk[11] = 8'h00;
        pk_n = 12;
        seal();
        e = '0; e.kind = 2'd1; e.ack = 8'h1E;
        exp_q.push_back(e);
        tx_frame();
        gap(40);
    endtask

    // header-only reject: only the bytes up to the size high byte are sent
    task automatic send_bad_hdr(input logic [7:0] typ, input logic [15:0] size, input string req);
        put_hdr(typ, size);
        pk_n = 5;
        tx_frame();
        gap(40);
        exp_err++;
        chk(err_count == 8'(exp_err), req, 64'(err_count), 64'(exp_err));
    endtask

    task automatic check_err(input string req);
        chk(err_count == 8'(exp_err), req, 64'(err_count), 64'(exp_err));
    endtask

    task automatic check_drained(input string req);
        chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected acknowledge", 64'(ack_byte), 64'd0);
                end else begin
                    me = exp_q.pop_front();
                    chk(ack_byte == me.ack, "R7 acknowledge code", 64'(ack_byte), 64'(me.ack));
                    if (me.kind == 2'd1) begin
                        chk(!evt_valid && !op_valid, "R7 setup raises no command",
                            64'({evt_valid, op_valid}), 64'd0);
                    end else if (me.kind == 2'd2) begin
                        chk(evt_valid && !op_valid, "R5 event valid",
                            64'({evt_valid, op_valid}), 64'd2);
                        chk(evt_id == me.eid, "R5 event id", 64'(evt_id), 64'(me.eid));
                        chk(evt_param == me.eprm, "R5 event param", 64'(evt_param), 64'(me.eprm));
                    end else begin
                        chk(op_valid && !evt_valid, "R6 operation valid",
                            64'({evt_valid, op_valid}), 64'd1);
                        chk(op_code == me.oc, "R6 op code", 64'(op_code), 64'(me.oc));
                        chk(op_id == me.oid, "R6 op id", 64'(op_id), 64'(me.oid));
                        chk(op_avail == me.oav, "R6 op avail", 64'(op_avail), 64'(me.oav));
                        chk(op_target == me.ow[31:0], "R6 op target", 64'(op_target), 64'(me.ow[31:0]));
                        chk(op_value == me.ow[63:32], "R6 op value", 64'(op_value), 64'(me.ow[63:32]));
                        chk(op_min == me.ow[95:64], "R6 op min", 64'(op_min), 64'(me.ow[95:64]));
                        chk(op_max == me.ow[127:96], "R6 op max", 64'(op_max), 64'(me.ow[127:96]));
                        chk(op_inc == me.ow[159:128], "R6 op inc", 64'(op_inc), 64'(me.ow[159:128]));
                    end
                end
            end else if (evt_valid || op_valid) begin
                chk(1'b0, "R7 command without acknowledge", 64'({evt_valid, op_valid}), 64'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        gap(5);
        chk(!ack_valid && !evt_valid && !op_valid && err_count == 8'd0, "R10 outputs during reset",
            64'({ack_valid, evt_valid, op_valid, err_count}), 64'd0);
        rst = 1'b0;
        gap(3);
        chk(!ack_valid && !evt_valid && !op_valid && err_count == 8'd0, "R10 outputs after reset",
            64'({ack_valid, evt_valid, op_valid, err_count}), 64'd0);

        // R5 / R2: event packets, little-endian fields
        send_event(16'h00C9, 32'h0000_0000);
        send_event(16'hA55A, 32'h1234_5678);
        check_drained("R5 events acknowledged");
        check_err("R8 good packets leave counter");

        // R6: operation packets
        send_oper(8'h01, 16'h02C7, 16'hCCCC, 160'h0);
        send_oper(8'h05, 16'h1357, 16'h0001,
                  {32'h0000_0002, 32'h0000_0000, 32'h0000_0064, 32'h7654_3210, 32'h89AB_CDEF});
        check_drained("R6 operations acknowledged");

        // R7: link setup answered with 0x1E
        send_setup();
        check_drained("R7 setup acknowledged");

        // R1: junk, a lone sync byte, then sync restart on a repeated 0xBE
        send_byte(8'h00);
        send_byte(8'hEF);
        send_byte(8'hBE);
        send_byte(8'h12);
        send_byte(8'hBE);
        send_event(16'h0BEE, 32'hDEAD_BEEF);
        check_drained("R1 packet after restart accepted");
        check_err("R1 junk is not an error");

        // R4: corrupted check field, corrupted payload
        build_event(16'h4444, 32'h5555_6666);
        pk[6] = pk[6] ^ 8'h01;
        tx_frame();
        gap(40);
        exp_err++;
        check_err("R4 bad check field counted");
        build_event(16'h4444, 32'h5555_6666);
        pk[10] = pk[10] ^ 8'h80;
        tx_frame();
        gap(40);
        exp_err++;
        check_err("R4 bad payload counted");
        check_drained("R4 no acknowledge on mismatch");

        // R3: type and size pairs
        send_bad_hdr(8'd0, 16'd6, "R3 type 0 rejected");
        send_bad_hdr(8'd4, 16'd6, "R3 type 4 rejected");
        send_bad_hdr(8'd2, 16'd25, "R3 event with wrong size rejected");
        send_bad_hdr(8'd1, 16'd6, "R3 setup with wrong size rejected");

        // R2: size high byte is significant
        send_bad_hdr(8'd2, 16'h0106, "R2 size high byte rejected");
        send_bad_hdr(8'd3, 16'h1900, "R2 swapped size rejected");
        check_drained("R8 no acknowledge on rejected header");

        // R9: stalled partial packet then a good one
        send_byte(8'hBE);
        send_byte(8'hEF);
        send_byte(8'h02);
        send_byte(8'h06);
        gap(60);
        send_event(16'h7777, 32'h0102_0304);
        check_drained("R9 packet after stall accepted");
        check_err("R9 stall not counted");

        // back to normal after errors
        send_oper(8'h03, 16'hFFFF, 16'h0000,
                  {32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0000_00FF, 32'hCCCC_CCCC});
        check_drained("R6 operation after errors");
        check_err("R8 final count");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule